// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

A combinational arithmetic unit that treats two 32-bit source words as packed lanes and computes one 32-bit result in the same cycle. It covers three families of operations. The first is unsigned add and subtract on two halfword lanes, with optional clamping to the lane range. The second is unsigned halving add and subtract on four byte lanes. The third is signed halving add and subtract, either on two halfword lanes or on the whole word. Halving results can be rounded half-up.

Each lane is computed with no carry or borrow crossing into its neighbours. The unsigned halfword operations also produce an overflow pulse. An external control register ORs this pulse into its sticky flag. Register file access, decode and flag storage sit outside the unit.

Top module: `simd_addsub`

## Requirements
- R1: With valid_i high, op_i = 0 (unsigned halfword add) and sat_i low, each 16-bit lane of result_o (lane 0 at bits 15:0, lane 1 at bits 31:16) is the low 16 bits of the lane sum. ovf_o is high when any lane sum exceeds 0xFFFF.
- R2: With op_i = 0 and sat_i high, a lane whose sum exceeds 0xFFFF reads 0xFFFF and ovf_o is high. The other lanes keep their exact sums.
- R3: With op_i = 1 (unsigned halfword subtract) and sat_i low, each lane is the difference modulo 2^16. ovf_o is high when, in any lane, the lane of a_i is smaller than the lane of b_i.
- R4: With op_i = 1 and sat_i high, a lane where a_i is smaller than b_i reads 0x0000 and ovf_o is high.
- R5: With op_i = 2 (add) or op_i = 3 (subtract), each of the four unsigned byte lanes (lane 0 at bits 7:0, ascending) is computed in widened precision. One is added when rnd_i is high, the value is shifted right by one, and the low 8 bits are kept.
- R6: With op_i = 4 (add) or op_i = 5 (subtract), each halfword lane is sign-extended, added or subtracted, incremented by rnd_i, arithmetically shifted right by one and truncated to 16 bits.
- R7: With op_i = 6 (add) or op_i = 7 (subtract), the whole words are treated as signed 32-bit values. The sum or difference is formed in 33-bit precision, incremented by rnd_i, arithmetically shifted right by one, and the low 32 bits are returned.
- R8: For op_i 2 to 7, ovf_o stays low and sat_i has no effect on result_o. For op_i 0 and 1, rnd_i has no effect on result_o or ovf_o.
- R9: Lanes are independent. Overflow in one halfword lane leaves the other lane exact, and ovf_o is the OR of the per-lane indications.
- R10: With valid_i low, result_o is 0 and ovf_o is low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 3 | Operation select, encoding as in the requirements |
| sat_i | input | 1 | Clamp enable for unsigned halfword add/subtract |
| rnd_i | input | 1 | Round-half-up enable for halving operations |
| a_i | input | 32 | First source word |
| b_i | input | 32 | Second source word |
| result_o | output | 32 | Packed result |
| ovf_o | output | 1 | Overflow pulse for the external sticky flag |

## Verification
The bound checker tracks the unsigned halfword lanes whenever their inputs change. It checks that the overflow pulse matches the lane comparisons for add and subtract. It checks that clamped lanes read 0xFFFF or 0x0000, that halving operations never flag, and that an idle unit outputs zeros. The rounding arithmetic of the byte, signed halfword and word halving paths can only be shown by the bench's comparisons against its model. The same holds for the insensitivity to the unused mode bit and for lane isolation at the edge values 0x0000, 0xFFFF, 0x7FFF and 0x8000.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_UADD_H  = 3'd0,
    OP_USUB_H  = 3'd1,
    OP_UAVGA_B = 3'd2,
    OP_UAVGS_B = 3'd3,
    OP_SAVGA_H = 3'd4,
    OP_SAVGS_H = 3'd5,
    OP_SAVGA_W = 3'd6,
    OP_SAVGS_W = 3'd7
  } simd_op_e;
endpackage

// File: rtl/simd_sat_lane.sv
module simd_sat_lane #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic          sub_i,
  input  logic          sat_i,
  output logic [LW-1:0] res_o,
  output logic          ovf_o
);
  logic [LW:0] acc;

  always_comb begin
    acc   = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
    // bit LW is carry-out on add, borrow (a < b) on subtract
    ovf_o = acc[LW];
    if (ovf_o && sat_i) res_o = sub_i ? '0 : '1;
    else                res_o = acc[LW-1:0];
  end
endmodule

// File: rtl/simd_avg_lane.sv
module simd_avg_lane #(
  parameter int LW     = 8,
  parameter bit SIGNED = 1'b0
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic          sub_i,
  input  logic          rnd_i,
  output logic [LW-1:0] res_o
);
  localparam int EW = LW + 1;

  logic [EW-1:0] ea, eb, acc;
  logic          lsb_unused;

  always_comb begin
    ea  = SIGNED ? {a_i[LW-1], a_i} : {1'b0, a_i};
    eb  = SIGNED ? {b_i[LW-1], b_i} : {1'b0, b_i};
    // one guard bit is enough: only bits LW:1 survive the halving
    acc = (sub_i ? (ea - eb) : (ea + eb)) + {{(EW-1){1'b0}}, rnd_i};
  end

  assign {res_o, lsb_unused} = acc;
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         valid_i,
  input  logic [2:0]   op_i,
  input  logic         sat_i,
  input  logic         rnd_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         ovf_o
);
  localparam int HW = W / 2;
  localparam int BW = W / 4;
  localparam int NH = W / HW;
  localparam int NB = W / BW;

  simd_op_e op;
  logic     sub;
  assign op  = simd_op_e'(op_i);
  assign sub = op_i[0];

  logic [W-1:0]  sat_res, bavg_res, havg_res, wavg_res;
  logic [NH-1:0] lane_ovf;

  for (genvar h = 0; h < NH; h++) begin : g_half
    simd_sat_lane #(.LW(HW)) u_sat (
      .a_i  (a_i[h*HW +: HW]),
      .b_i  (b_i[h*HW +: HW]),
      .sub_i(sub),
      .sat_i(sat_i),
      .res_o(sat_res[h*HW +: HW]),
      .ovf_o(lane_ovf[h])
    );
    simd_avg_lane #(.LW(HW), .SIGNED(1'b1)) u_savg (
      .a_i  (a_i[h*HW +: HW]),
      .b_i  (b_i[h*HW +: HW]),
      .sub_i(sub),
      .rnd_i(rnd_i),
      .res_o(havg_res[h*HW +: HW])
    );
  end

  for (genvar q = 0; q < NB; q++) begin : g_byte
    simd_avg_lane #(.LW(BW), .SIGNED(1'b0)) u_uavg (
      .a_i  (a_i[q*BW +: BW]),
      .b_i  (b_i[q*BW +: BW]),
      .sub_i(sub),
      .rnd_i(rnd_i),
      .res_o(bavg_res[q*BW +: BW])
    );
  end

  simd_avg_lane #(.LW(W), .SIGNED(1'b1)) u_wavg (
    .a_i  (a_i),
    .b_i  (b_i),
    .sub_i(sub),
    .rnd_i(rnd_i),
    .res_o(wavg_res)
  );

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_UADD_H, OP_USUB_H: begin
          result_o = sat_res;
          ovf_o    = |lane_ovf;
        end
        OP_UAVGA_B, OP_UAVGS_B: result_o = bavg_res;
        OP_SAVGA_H, OP_SAVGS_H: result_o = havg_res;
        default:                result_o = wavg_res;
      endcase
    end
  end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int W = 32
) (
  input logic         valid_i,
  input logic [2:0]   op_i,
  input logic         sat_i,
  input logic         rnd_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic         ovf_o
);
  localparam int HW = W / 2;

  logic add_any, sub_any;
  logic rnd_unused;
  assign rnd_unused = rnd_i;

  always_comb begin
    add_any = 1'b0;
    sub_any = 1'b0;
    for (int h = 0; h < 2; h++) begin
      if (({1'b0, a_i[h*HW +: HW]} + {1'b0, b_i[h*HW +: HW]}) > {1'b0, {HW{1'b1}}}) add_any = 1'b1;
      if (a_i[h*HW +: HW] < b_i[h*HW +: HW]) sub_any = 1'b1;
    end

    if (!valid_i)
      assert_idle_quiet_R10: assert (result_o == '0 && !ovf_o);

    if (valid_i && op_i >= 3'd2)
      assert_halving_no_ovf_R8: assert (!ovf_o);

    if (valid_i && op_i == 3'd0)
      assert_add_ovf_R1: assert (ovf_o == add_any);

    if (valid_i && op_i == 3'd1)
      assert_sub_ovf_R3: assert (ovf_o == sub_any);

    for (int h = 0; h < 2; h++) begin
      if (valid_i && op_i == 3'd0 && sat_i &&
          ({1'b0, a_i[h*HW +: HW]} + {1'b0, b_i[h*HW +: HW]}) > {1'b0, {HW{1'b1}}})
        assert_add_clamp_R2: assert (result_o[h*HW +: HW] == {HW{1'b1}});
      if (valid_i && op_i == 3'd1 && sat_i && a_i[h*HW +: HW] < b_i[h*HW +: HW])
        assert_sub_clamp_R4: assert (result_o[h*HW +: HW] == '0);
    end
  end
endmodule

bind simd_addsub simd_addsub_chk #(.W(W)) u_chk (.*);

// File: tb/simd_addsub_tb.sv
`timescale 1ns/1ps
module simd_addsub_tb;
  logic        clk = 1'b0;
  logic        valid_i, sat_i, rnd_i;
  logic [2:0]  op_i;
  logic [31:0] a_i, b_i, result_o;
  logic        ovf_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  simd_addsub u_dut (
    .valid_i (valid_i),
    .op_i    (op_i),
    .sat_i   (sat_i),
    .rnd_i   (rnd_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .result_o(result_o),
    .ovf_o   (ovf_o)
  );

  function automatic logic [32:0] model(input logic v, input logic [2:0] op, input logic sat,
                                        input logic rnd, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    logic        f = 1'b0;
    if (!v) return 33'd0;
    case (op)
      3'd0, 3'd1: for (int i = 0; i < 2; i++) begin
        int x = int'(a[16*i +: 16]);
        int y = int'(b[16*i +: 16]);
        int s;
        if (op == 3'd0) begin
          s = x + y;
          if (s > 65535) begin f = 1'b1; if (sat) s = 65535; end
        end else begin
          s = x - y;
          if (x < y) begin f = 1'b1; if (sat) s = 0; end
        end
        r[16*i +: 16] = s[15:0];
      end
      3'd2, 3'd3: for (int i = 0; i < 4; i++) begin
        int x = int'(a[8*i +: 8]);
        int y = int'(b[8*i +: 8]);
        int s = ((op == 3'd2) ? x + y : x - y) + int'(rnd);
        s = s >>> 1;
        r[8*i +: 8] = s[7:0];
      end
      3'd4, 3'd5: for (int i = 0; i < 2; i++) begin
        logic signed [15:0] hx = a[16*i +: 16];
        logic signed [15:0] hy = b[16*i +: 16];
        int x = hx;
        int y = hy;
        int s = ((op == 3'd4) ? x + y : x - y) + int'(rnd);
        s = s >>> 1;
        r[16*i +: 16] = s[15:0];
      end
      default: begin
        logic signed [31:0] wx = a;
        logic signed [31:0] wy = b;
        longint x = wx;
        longint y = wy;
        longint s = ((op == 3'd6) ? x + y : x - y) + longint'(rnd);
        s = s >>> 1;
        r = s[31:0];
      end
    endcase
    return {f, r};
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic sat);
    case (op)
      3'd0:       return sat ? "R2" : "R1";
      3'd1:       return sat ? "R4" : "R3";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic apply(input logic v, input logic [2:0] op, input logic sat, input logic rnd,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [32:0] e;
    @(negedge clk);
    valid_i = v; op_i = op; sat_i = sat; rnd_i = rnd; a_i = a; b_i = b;
    #1;
    e = model(v, op, sat, rnd, a, b);
    n_chk++;
    if (result_o !== e[31:0]) begin
      n_fail++;
      $display("FAIL %s result op=%0d sat=%0b rnd=%0b a=%h b=%h actual=%h expected=%h",
               tag, op, sat, rnd, a, b, result_o, e[31:0]);
    end
    n_chk++;
    if (ovf_o !== e[32]) begin
      n_fail++;
      $display("FAIL %s ovf op=%0d a=%h b=%h actual=%0b expected=%0b", tag, op, a, b, ovf_o, e[32]);
    end
  endtask

  task automatic expect_word(input logic [31:0] exp_r, input logic exp_f, input string tag);
    n_chk++;
    if (result_o !== exp_r || ovf_o !== exp_f) begin
      n_fail++;
      $display("FAIL %s actual=%h/%0b expected=%h/%0b", tag, result_o, ovf_o, exp_r, exp_f);
    end
  endtask

  initial begin
    logic [15:0] edges [4] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000};
    int unsigned seed_unused = $urandom(32'd20240611);
    valid_i = 1'b0; op_i = '0; sat_i = 1'b0; rnd_i = 1'b0; a_i = '0; b_i = '0;
    #1;
    expect_word(32'h0, 1'b0, "R10 reset idle");

    // R10: idle with active-looking inputs
    apply(1'b0, 3'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
    expect_word(32'h0, 1'b0, "R10 idle overflow inputs");

    // R9: overflow in lane 1 only, lane 0 exact
    apply(1'b1, 3'd0, 1'b1, 1'b0, 32'hFFF0_0001, 32'h0020_0002, "R9");
    expect_word(32'hFFFF_0003, 1'b1, "R9 lane isolation add");
    apply(1'b1, 3'd1, 1'b0, 1'b0, 32'h0005_0001, 32'h0003_0002, "R9");
    expect_word(32'h0002_FFFF, 1'b1, "R9 lane isolation sub");

    // R8: sat ignored for halving, rnd ignored for saturating ops
    apply(1'b1, 3'd2, 1'b1, 1'b1, 32'hFF01_80FF, 32'hFF00_7F01, "R8");
    expect_word(32'hFF01_8080, 1'b0, "R8 byte avg with sat set");
    apply(1'b1, 3'd0, 1'b0, 1'b1, 32'h0001_0001, 32'h0001_0001, "R8");
    expect_word(32'h0002_0002, 1'b0, "R8 add with rnd set");

    // R5, R6, R7 spot values
    apply(1'b1, 3'd3, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001, "R5");
    expect_word(32'h0000_00FF, 1'b0, "R5 byte sub wrap");
    apply(1'b1, 3'd4, 1'b0, 1'b1, 32'h7FFF_0001, 32'h7FFF_0000, "R6");
    expect_word(32'h7FFF_0001, 1'b0, "R6 signed half round");
    apply(1'b1, 3'd7, 1'b0, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, "R7");
    expect_word(32'h8000_0000, 1'b0, "R7 word sub extreme");
    apply(1'b1, 3'd6, 1'b0, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R7");
    expect_word(32'h7FFF_FFFF, 1'b0, "R7 word add extreme");

    // edge-value sweep over every operation and mode
    for (int ia = 0; ia < 16; ia++)
      for (int ib = 0; ib < 16; ib++)
        for (int op = 0; op < 8; op++)
          for (int m = 0; m < 4; m++)
            apply(1'b1, op[2:0], m[0], m[1], {edges[ia/4], edges[ia%4]}, {edges[ib/4], edges[ib%4]},
                  tag_of(op[2:0], m[0]));

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      logic [2:0]  op = 3'($urandom_range(0, 7));
      logic        sa = 1'($urandom_range(0, 1));
      logic        rn = 1'($urandom_range(0, 1));
      logic        vl = ($urandom_range(0, 15) != 0);
      logic [31:0] a  = $urandom;
      logic [31:0] b  = $urandom;
      apply(vl, op, sa, rn, a, b, vl ? tag_of(op, sa) : "R10");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule